// File: doc/BRIEF.md
# Multi-Queue ADC Command Dispatcher

This block sits between a host processor or DMA engine and the command buffer of an analog-to-digital converter. It keeps six independent command queues. The host pushes 32-bit command messages into them one word per cycle. The dispatcher picks one queue head each cycle and offers it on a ready/valid command port. Each queue raises its own refill strobe while it has enough free room, so that an interrupt or DMA channel can top it up.

Every command word carries a small header in its two top bits. The header names the target command buffer, and the dispatcher brings it out on a separate port. Normal dispatch takes the lowest-numbered queue that holds a command. One queue can be chosen as the immediate-conversion queue, and its head then goes ahead of all others. Queue 0 can be set to a streaming mode in which it never pops in a cycle in which it is also pushed. An abort input empties a chosen queue in one cycle.

Top module: `cqd_dispatch`

## Requirements
- R1: After reset, all queues are empty, `cmd_valid` is 0, `overflow` is all zeros, and `fill_req[i]` is 1 for every queue whenever the watermark is at most the queue depth (4).
- R2: Within one queue, commands leave in the order they were pushed. Among queues that are not the immediate queue, the lowest index that holds a command is offered first.
- R3: `cmd_tgt` equals bits [31:30] of the offered command word, `cmd_data` is the whole word unchanged, and `cmd_src` is the index of the queue it came from.
- R4: When `cfg_imm_en` is 1 and queue `cfg_imm_sel` holds a command, that queue's head is offered in preference to every other queue.
- R5: `fill_req[i]` is 1 only while the free-entry count of queue i (depth minus entries) is at or above `cfg_watermark`.
- R6: `fill_req[i]` is 0 in every cycle in which queue i holds depth (4) entries, even when the watermark is 0.
- R7: A push into a full queue is dropped and leaves that queue's contents unchanged. It sets `overflow[i]`, which stays at 1 until reset.
- R8: A push and a pop on the same queue in the same cycle are both carried out, except for the case in R9.
- R9: With `cfg_stream0` at 1, queue 0 is not offered in any cycle in which `push_en` is 1 with `push_sel` equal to 0. The push is still accepted.
- R10: A cycle with `abort_en` at 1 empties queue `abort_sel` and drops any push to that queue in that cycle. In the following cycle that queue's `fill_req` is 0, and after that it follows R5 again.
- R11: While `cmd_ready` is 0, nothing is popped, and the offered word stays the same as long as no higher-priority queue gains a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_en | input | 1 | Write one command word this cycle |
| push_sel | input | 3 | Queue receiving the push |
| push_data | input | 32 | Command word, header in bits [31:30] |
| abort_en | input | 1 | Flush one queue this cycle |
| abort_sel | input | 3 | Queue to flush |
| cfg_watermark | input | 3 | Free-entry threshold for refill strobes |
| cfg_imm_en | input | 1 | Enable the immediate-conversion queue |
| cfg_imm_sel | input | 3 | Index of the immediate queue |
| cfg_stream0 | input | 1 | Streaming mode for queue 0 |
| cmd_valid | output | 1 | A command is offered |
| cmd_ready | input | 1 | The command buffer takes the offered command |
| cmd_data | output | 32 | Offered command word |
| cmd_tgt | output | 2 | Target-buffer field of the offered word |
| cmd_src | output | 3 | Queue the offered word came from |
| fill_req | output | 6 | Per-queue refill strobe |
| overflow | output | 6 | Per-queue sticky overflow flag |

## Verification
The hardest case to reach is the streaming-mode conflict on queue 0. For it to show, queue 0 must be the only queue that holds anything, the command buffer must be ready, and a push into queue 0 must arrive in that same cycle. The bench first loads a single word into queue 0 and leaves every other queue empty. It then raises the push and `cmd_ready` on the same falling edge. This checks that nothing is offered in that cycle, and that both words then leave in order. The abort-versus-refill sequence is set up the same way: a queue is filled part way, and the flush and the strobe are checked in the cycle after the abort and in the cycle after that.

// File: rtl/cqd_pkg.sv
package cqd_pkg;
    parameter int NUM_Q  = 6;
    parameter int DEPTH  = 4;
    parameter int WORD_W = 32;
    parameter int TGT_W  = 2;
    localparam int QW = $clog2(NUM_Q);
    localparam int CW = $clog2(DEPTH + 1);
endpackage

// File: rtl/cqd_fifo.sv
module cqd_fifo #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 32,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int PW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic              pop,
    input  logic [WORD_W-1:0] wdata,
    input  logic [CW-1:0]     watermark,
    output logic [WORD_W-1:0] rdata,
    output logic [CW-1:0]     count,
    output logic              fill_req,
    output logic              overflow
);
    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [PW-1:0]                wr;
        logic [PW-1:0]                rd;
        logic [CW-1:0]                cnt;
        logic                         flushed;
        logic                         ovf;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic     full, take, give;

    always_comb begin
        s_d         = s_q;
        s_d.flushed = 1'b0;
        full        = (s_q.cnt == CW'(DEPTH));
        take        = push && !full && !flush;
        give        = pop && (s_q.cnt != '0) && !flush;
        if (flush) begin
            s_d.cnt     = '0;
            s_d.wr      = '0;
            s_d.rd      = '0;
            s_d.flushed = 1'b1;
        end else begin
            if (push && full)
                s_d.ovf = 1'b1;
            if (take) begin
                s_d.mem[s_q.wr] = wdata;
                s_d.wr = (s_q.wr == PW'(DEPTH - 1)) ? '0 : s_q.wr + 1'b1;
            end
            if (give)
                s_d.rd = (s_q.rd == PW'(DEPTH - 1)) ? '0 : s_q.rd + 1'b1;
            s_d.cnt = s_q.cnt + CW'(take) - CW'(give);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rdata    = s_q.mem[s_q.rd];
    assign count    = s_q.cnt;
    assign overflow = s_q.ovf;
    assign fill_req = !s_q.flushed && !full && ((CW'(DEPTH) - s_q.cnt) >= watermark);
endmodule

// File: rtl/cqd_arbiter.sv
module cqd_arbiter #(
    parameter int NUM_Q = 6,
    localparam int QW = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] avail,
    input  logic             imm_en,
    input  logic [QW-1:0]    imm_sel,
    output logic [NUM_Q-1:0] grant,
    output logic [QW-1:0]    idx,
    output logic             any
);
    logic imm_hit;

    always_comb begin
        grant   = '0;
        idx     = '0;
        any     = 1'b0;
        imm_hit = 1'b0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (imm_en && imm_sel == QW'(i) && avail[i]) begin
                imm_hit  = 1'b1;
                grant[i] = 1'b1;
                idx      = QW'(i);
                any      = 1'b1;
            end
        end
        if (!imm_hit) begin
            for (int i = NUM_Q - 1; i >= 0; i--) begin
                if (avail[i]) begin
                    grant    = '0;
                    grant[i] = 1'b1;
                    idx      = QW'(i);
                    any      = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cqd_dispatch.sv
module cqd_dispatch
    import cqd_pkg::*;
#(
    parameter int NUM_Q  = cqd_pkg::NUM_Q,
    parameter int DEPTH  = cqd_pkg::DEPTH,
    parameter int WORD_W = cqd_pkg::WORD_W,
    parameter int TGT_W  = cqd_pkg::TGT_W,
    localparam int QW = $clog2(NUM_Q),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [QW-1:0]     push_sel,
    input  logic [WORD_W-1:0] push_data,
    input  logic              abort_en,
    input  logic [QW-1:0]     abort_sel,
    input  logic [CW-1:0]     cfg_watermark,
    input  logic              cfg_imm_en,
    input  logic [QW-1:0]     cfg_imm_sel,
    input  logic              cfg_stream0,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [WORD_W-1:0] cmd_data,
    output logic [TGT_W-1:0]  cmd_tgt,
    output logic [QW-1:0]     cmd_src,
    output logic [NUM_Q-1:0]  fill_req,
    output logic [NUM_Q-1:0]  overflow
);
    logic [NUM_Q-1:0][CW-1:0] q_cnt;
    logic [WORD_W-1:0]        q_head [NUM_Q];
    logic [NUM_Q-1:0]         avail, grant, q_push, q_flush;

    for (genvar i = 0; i < NUM_Q; i++) begin : g_q
        assign q_push[i]  = push_en && (push_sel == QW'(i));
        assign q_flush[i] = abort_en && (abort_sel == QW'(i));
        if (i == 0) begin : g_stream
            assign avail[i] = (q_cnt[i] != '0) && !q_flush[i] && !(cfg_stream0 && q_push[i]);
        end else begin : g_plain
            assign avail[i] = (q_cnt[i] != '0) && !q_flush[i];
        end

        cqd_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .flush     (q_flush[i]),
            .push      (q_push[i]),
            .pop       (grant[i] && cmd_ready),
            .wdata     (push_data),
            .watermark (cfg_watermark),
            .rdata     (q_head[i]),
            .count     (q_cnt[i]),
            .fill_req  (fill_req[i]),
            .overflow  (overflow[i])
        );
    end

    cqd_arbiter #(.NUM_Q(NUM_Q)) u_arb (
        .avail   (avail),
        .imm_en  (cfg_imm_en),
        .imm_sel (cfg_imm_sel),
        .grant   (grant),
        .idx     (cmd_src),
        .any     (cmd_valid)
    );

    always_comb begin
        cmd_data = '0;
        for (int i = 0; i < NUM_Q; i++)
            if (grant[i]) cmd_data = q_head[i];
    end

    assign cmd_tgt = cmd_data[WORD_W-1 -: TGT_W];
endmodule

// File: rtl/cqd_dispatch_chk.sv
module cqd_dispatch_chk #(
    parameter int NUM_Q = 6,
    parameter int DEPTH = 4,
    localparam int QW = $clog2(NUM_Q),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     push_en,
    input logic [QW-1:0]            push_sel,
    input logic                     abort_en,
    input logic [QW-1:0]            abort_sel,
    input logic [CW-1:0]            cfg_watermark,
    input logic                     cfg_stream0,
    input logic                     cmd_valid,
    input logic [QW-1:0]            cmd_src,
    input logic [NUM_Q-1:0]         fill_req,
    input logic [NUM_Q-1:0]         overflow,
    input logic [NUM_Q-1:0][CW-1:0] q_cnt
);
    for (genvar i = 0; i < NUM_Q; i++) begin : g_chk
        a_r5_req_watermark: assert property (@(posedge clk) disable iff (!rst_n)
            fill_req[i] |-> ((CW'(DEPTH) - q_cnt[i]) >= cfg_watermark));
        a_r6_full_no_req: assert property (@(posedge clk) disable iff (!rst_n)
            (q_cnt[i] == CW'(DEPTH)) |-> !fill_req[i]);
        a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            overflow[i] |=> overflow[i]);
        a_r10_abort_flush: assert property (@(posedge clk) disable iff (!rst_n)
            (abort_en && abort_sel == QW'(i)) |=> (q_cnt[i] == '0) && !fill_req[i]);
    end

    a_r9_stream_no_pop0: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_stream0 && push_en && push_sel == '0) |-> !(cmd_valid && cmd_src == '0));
    a_r2_valid_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (q_cnt[cmd_src] != '0));
endmodule

bind cqd_dispatch cqd_dispatch_chk #(.NUM_Q(NUM_Q), .DEPTH(DEPTH)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .push_en       (push_en),
    .push_sel      (push_sel),
    .abort_en      (abort_en),
    .abort_sel     (abort_sel),
    .cfg_watermark (cfg_watermark),
    .cfg_stream0   (cfg_stream0),
    .cmd_valid     (cmd_valid),
    .cmd_src       (cmd_src),
    .fill_req      (fill_req),
    .overflow      (overflow),
    .q_cnt         (q_cnt)
);

// File: tb/cqd_dispatch_bench.sv
module cqd_dispatch_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        push_en, abort_en, cfg_imm_en, cfg_stream0, cmd_ready;
    logic [2:0]  push_sel, abort_sel, cfg_imm_sel, cfg_watermark, cmd_src;
    logic [31:0] push_data, cmd_data;
    logic [1:0]  cmd_tgt;
    logic        cmd_valid;
    logic [5:0]  fill_req, overflow;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    cqd_dispatch u_cqd_dispatch (
        .clk(clk), .rst_n(rst_n), .push_en(push_en), .push_sel(push_sel),
        .push_data(push_data), .abort_en(abort_en), .abort_sel(abort_sel),
        .cfg_watermark(cfg_watermark), .cfg_imm_en(cfg_imm_en),
        .cfg_imm_sel(cfg_imm_sel), .cfg_stream0(cfg_stream0),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
        .cmd_tgt(cmd_tgt), .cmd_src(cmd_src), .fill_req(fill_req),
        .overflow(overflow)
    );

    // {queue, word}
    localparam logic [34:0] VEC [8] = '{
        {3'd3, 32'h4000_0031}, {3'd1, 32'h8000_0011}, {3'd3, 32'hC000_0032},
        {3'd5, 32'h0000_0051}, {3'd1, 32'h4000_0012}, {3'd0, 32'h8000_0001},
        {3'd5, 32'hC000_0052}, {3'd3, 32'h0000_0033}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; push_en = 0; abort_en = 0; cfg_imm_en = 0; cfg_stream0 = 0;
        cmd_ready = 0; push_sel = 0; abort_sel = 0; cfg_imm_sel = 0;
        cfg_watermark = 3'd2; push_data = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic push(input logic [2:0] q, input logic [31:0] d);
        push_en = 1'b1; push_sel = q; push_data = d;
        tick();
        push_en = 1'b0;
    endtask

    task automatic pop_expect(input string tag, input logic [2:0] q, input logic [31:0] d);
        cmd_ready = 1'b1;
        #1;
        check(tag, {31'd0, cmd_valid}, 32'd1);
        check(tag, cmd_data, d);
        check(tag, {29'd0, cmd_src}, {29'd0, q});
        check("R3 tgt", {30'd0, cmd_tgt}, {30'd0, d[31:30]});
        tick();
        cmd_ready = 1'b0;
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] exp_d [8];
        logic [2:0]  exp_q [8];
        int          n;

        // R1 reset state
        do_reset();
        check("R1 valid", {31'd0, cmd_valid}, 32'd0);
        check("R1 fill_req", {26'd0, fill_req}, 32'h3F);
        check("R1 overflow", {26'd0, overflow}, 32'd0);

        // R2/R3 table walk: push all, then drain in priority and FIFO order
        n = 0;
        for (int q = 0; q < 6; q++)
            for (int k = 0; k < 8; k++)
                if (VEC[k][34:32] == 3'(q)) begin
                    exp_d[n] = VEC[k][31:0];
                    exp_q[n] = 3'(q);
                    n++;
                end
        for (int k = 0; k < 8; k++) push(VEC[k][34:32], VEC[k][31:0]);
        for (int k = 0; k < 8; k++) pop_expect("R2 order", exp_q[k], exp_d[k]);
        #1 check("R2 drained", {31'd0, cmd_valid}, 32'd0);

        // R4 immediate queue preempts lower index
        do_reset();
        push(3'd0, 32'h0000_00A0);
        push(3'd4, 32'h4000_00B4);
        #1 check("R4 normal", cmd_data, 32'h0000_00A0);
        cfg_imm_en = 1'b1; cfg_imm_sel = 3'd4;
        #1 check("R4 imm data", cmd_data, 32'h4000_00B4);
        check("R4 imm src", {29'd0, cmd_src}, 32'd4);

        // R11 hold under backpressure
        tick(); tick();
        check("R11 hold", cmd_data, 32'h4000_00B4);
        check("R11 valid", {31'd0, cmd_valid}, 32'd1);

        // R5 watermark
        do_reset();
        push(3'd2, 32'h1);
        push(3'd2, 32'h2);
        check("R5 free2", {31'd0, fill_req[2]}, 32'd1);
        push(3'd2, 32'h3);
        check("R5 free1", {31'd0, fill_req[2]}, 32'd0);

        // R6 full with watermark 0, R7 overflow
        do_reset();
        cfg_watermark = 3'd0;
        for (int k = 0; k < 3; k++) push(3'd4, 32'h40 + 32'(k));
        check("R6 not full", {31'd0, fill_req[4]}, 32'd1);
        push(3'd4, 32'h43);
        check("R6 full", {31'd0, fill_req[4]}, 32'd0);
        push(3'd4, 32'h44);
        check("R7 ovf", {26'd0, overflow}, 32'h10);
        for (int k = 0; k < 4; k++) pop_expect("R7 contents", 3'd4, 32'h40 + 32'(k));
        #1 check("R7 dropped", {31'd0, cmd_valid}, 32'd0);
        check("R7 sticky", {26'd0, overflow}, 32'h10);

        // R8 simultaneous push and pop on queue 1
        do_reset();
        push(3'd1, 32'hD1);
        push_en = 1'b1; push_sel = 3'd1; push_data = 32'hD2;
        pop_expect("R8 pop", 3'd1, 32'hD1);
        push_en = 1'b0;
        pop_expect("R8 push kept", 3'd1, 32'hD2);
        #1 check("R8 empty", {31'd0, cmd_valid}, 32'd0);

        // R9 streaming mode on queue 0
        do_reset();
        cfg_stream0 = 1'b1;
        push(3'd0, 32'hE1);
        push_en = 1'b1; push_sel = 3'd0; push_data = 32'hE2; cmd_ready = 1'b1;
        #1 check("R9 blocked", {31'd0, cmd_valid}, 32'd0);
        tick();
        push_en = 1'b0; cmd_ready = 1'b0;
        pop_expect("R9 first", 3'd0, 32'hE1);
        pop_expect("R9 second", 3'd0, 32'hE2);

        // R10 abort
        do_reset();
        push(3'd3, 32'h31);
        push(3'd3, 32'h32);
        abort_en = 1'b1; abort_sel = 3'd3;
        push_en = 1'b1; push_sel = 3'd3; push_data = 32'h33;
        tick();
        abort_en = 1'b0; push_en = 1'b0;
        check("R10 req low", {31'd0, fill_req[3]}, 32'd0);
        check("R10 flushed", {31'd0, cmd_valid}, 32'd0);
        tick();
        check("R10 req back", {31'd0, fill_req[3]}, 32'd1);
        check("R10 still empty", {31'd0, cmd_valid}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule